// File: doc/BRIEF.md
# Signed Byte Load Execution Unit

This unit executes one load of a signed byte per accepted instruction word. It takes the 32-bit word together with the base register value and the index register value, which the surrounding pipeline has already read out of its register file. It decodes which addressing form the word uses and forms the effective address. It then sends a single one-byte read over a valid/ready memory request port and waits for the returning byte. The byte comes back sign-extended to the register width that the word selects. When the form writes the base back, the updated base value comes back with it.

Words that do not encode a signed byte load are reported as undefined. When the base is the stack pointer and it is not 16-byte aligned, the unit reports an alignment fault. In both of those cases it makes no memory access and asks for no writeback. The unit has no condition-flag output, so it cannot alter any flags. Register file updates, exception entry and translation stay with the caller, which acts on the completion outputs.

Top module: `sbl_unit`

## Requirements
- R1: A word is decoded only when it matches one of four forms, with bit 23 = 1 in every form.
  - Unsigned immediate: bits[31:23] = 001110011.
  - Post-index: bits[31:24] = 00111000, bit 21 = 0, bits[11:10] = 01.
  - Pre-index: bits[31:24] = 00111000, bit 21 = 0, bits[11:10] = 11.
  - Register offset: bits[31:24] = 00111000, bit 21 = 1, bits[11:10] = 10.
  - Any other word completes with `done_undef` = 1, raises no memory request and has `done_wb_en` = 0.
- R2: In the unsigned immediate form, the address is base + zero-extended bits[21:10]. No writeback is requested.
- R3: In the pre-index form, the address is base + sign-extended bits[20:12]. That same address is returned on `done_wb_addr` with `done_wb_en` = 1 and `done_wb_reg` = bits[9:5].
- R4: In the post-index form, the address is the unmodified base. The value base + sign-extended bits[20:12] is returned for writeback with `done_wb_en` = 1.
- R5: In the register offset form, the address is base + offset, where the offset depends on bits[15:13]:
  - 010: zero-extended low 32 bits of the index.
  - 110: sign-extended low 32 bits of the index.
  - 011 or 111: the full 64-bit index.
  - Bit 12 never shifts the offset. Any other value of bits[15:13] makes the word undefined.
- R6: Bit 22 = 1 returns the byte sign-extended to 32 bits with bits[63:32] = 0. Bit 22 = 0 returns it sign-extended to 64 bits. `done_rt` carries bits[4:0].
- R7: When bits[9:5] = 31 and bits[3:0] of the base are not all zero, the load completes with `done_align_fault` = 1. It raises no memory request and has `done_wb_en` = 0.
- R8: Exactly one memory request is made per valid load. `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen.
- R9: `done_valid` pulses for one cycle. It comes the cycle after the response is accepted, or the cycle after issue for an undefined or faulting word. `issue_ready` is low from acceptance until completion, and words presented during that time are ignored.
- R10: After reset, `issue_ready` = 1, `mem_req_valid` = 0 and `done_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Instruction word offered |
| issue_ready | output | 1 | Unit idle and accepting |
| issue_instr | input | 32 | Instruction word |
| issue_base | input | 64 | Value of the base register, or of the stack pointer when bits[9:5] = 31 |
| issue_index | input | 64 | Value of the index register for the register offset form |
| mem_req_valid | output | 1 | Byte read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 8 | Returned byte |
| done_valid | output | 1 | Completion pulse |
| done_rt | output | 5 | Destination register number |
| done_result | output | 64 | Sign-extended result |
| done_wb_en | output | 1 | Base writeback requested |
| done_wb_reg | output | 5 | Base register number for writeback |
| done_wb_addr | output | 64 | Base writeback value |
| done_undef | output | 1 | Word was not a signed byte load |
| done_align_fault | output | 1 | Stack pointer base misaligned |

## Verification
Each addressing form is driven with immediates that check the extension rules.
- Largest unsigned offset: shows that bits[21:10] are zero-extended.
- Signed offsets of -1, -256 and +255: show that bits[20:12] are sign-extended and that pre-index and post-index are not swapped.
- Register offset with an index whose upper half is nonzero: tells zero-extension, sign-extension and full-width use apart, and the set bit 12 shows that no shift is applied.
- Returned bytes 0x80, 0x7F and 0xF0 at both widths: separate sign-extension from zero-extension and check the zeroed upper word.
- Stack pointer base, aligned and misaligned, and several undefined words: show that no request is raised.
- A stalled request with another word offered meanwhile: checks that the request holds and that the unit ignores input while busy.

// File: rtl/sbl_pkg.sv
// Package: shared types for the signed byte load unit.
// Assumes: 32-bit instruction words and a 64-bit register width.
package sbl_pkg;
    localparam int INSTR_W = 32;
    localparam int REG_IDX_W = 5;

    typedef enum logic [2:0] {
        AM_NONE,
        AM_UIMM,
        AM_PRE,
        AM_POST,
        AM_REG
    } amode_e;

    typedef struct packed {
        amode_e         mode;
        logic           w32;
        logic [4:0]     rn;
        logic [4:0]     rt;
        logic [11:0]    imm12;
        logic [8:0]     imm9;
        logic [2:0]     ext_opt;
    } dec_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_DONE
    } state_e;
endpackage

// File: rtl/sbl_decode.sv
// Module: sbl_decode
// Classifies an instruction word into one of the four signed byte load
// forms, or AM_NONE, and extracts its fields. Purely combinational.
// Assumes: the caller treats AM_NONE as undefined.
module sbl_decode
    import sbl_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic grp_uimm;
    logic grp_idx;

    // Purpose: match the fixed opcode bits shared by each group of forms.
    always_comb begin
        grp_uimm = (instr[31:23] == 9'b0011_1001_1);
        grp_idx  = (instr[31:23] == 9'b0011_1000_1);
    end

    // Purpose: select the addressing mode and split out the fields.
    always_comb begin
        dec.mode    = AM_NONE;
        dec.w32     = instr[22];
        dec.rn      = instr[9:5];
        dec.rt      = instr[4:0];
        dec.imm12   = instr[21:10];
        dec.imm9    = instr[20:12];
        dec.ext_opt = instr[15:13];
        if (grp_uimm) begin
            dec.mode = AM_UIMM;
        end else if (grp_idx) begin
            if (!instr[21]) begin
                if (instr[11:10] == 2'b01)
                    dec.mode = AM_POST;
                else if (instr[11:10] == 2'b11)
                    dec.mode = AM_PRE;
            end else if (instr[11:10] == 2'b10 && instr[14]) begin
                dec.mode = AM_REG;
            end
        end
    end
endmodule

// File: rtl/sbl_agen.sv
// Module: sbl_agen
// Forms the offset for the decoded mode, then the access address, the
// writeback value and the stack pointer alignment check.
// Assumes: base already holds SP when rn is 31; index holds the Rm value.
module sbl_agen
    import sbl_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter int SP_ALIGN_LG = 4,
    parameter int HALF_W      = XLEN / 2
) (
    input  dec_t            dec,
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] index,
    output logic [XLEN-1:0] acc_addr,
    output logic [XLEN-1:0] wb_addr,
    output logic            wb_en,
    output logic            align_fault
);
    localparam int IMM12_W = 12;
    localparam int IMM9_W  = 9;

    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] sum;

    // Purpose: build the offset; byte access means no scaling or shift.
    always_comb begin
        offset = '0;
        unique case (dec.mode)
            AM_UIMM: offset = {{(XLEN-IMM12_W){1'b0}}, dec.imm12};
            AM_PRE, AM_POST:
                offset = {{(XLEN-IMM9_W){dec.imm9[IMM9_W-1]}}, dec.imm9};
            AM_REG: begin
                if (dec.ext_opt[0])
                    offset = index;
                else if (dec.ext_opt[2])
                    offset = {{(XLEN-HALF_W){index[HALF_W-1]}}, index[HALF_W-1:0]};
                else
                    offset = {{(XLEN-HALF_W){1'b0}}, index[HALF_W-1:0]};
            end
            default: offset = '0;
        endcase
    end

    // Purpose: add, pick pre or post use, and check SP alignment.
    always_comb begin
        sum         = base + offset;
        acc_addr    = (dec.mode == AM_POST) ? base : sum;
        wb_addr     = sum;
        wb_en       = (dec.mode == AM_PRE) || (dec.mode == AM_POST);
        align_fault = (dec.mode != AM_NONE) && (dec.rn == 5'd31) &&
                      (base[SP_ALIGN_LG-1:0] != '0);
    end
endmodule

// File: rtl/sbl_sext.sv
// Module: sbl_sext
// Sign-extends a byte to the full register or to its low half, with the
// upper half cleared in the narrow case.
// Assumes: XLEN is twice the narrow width.
module sbl_sext #(
    parameter int XLEN   = 64,
    parameter int BYTE_W = 8,
    parameter int HALF_W = XLEN / 2
) (
    input  logic [BYTE_W-1:0] data,
    input  logic              w32,
    output logic [XLEN-1:0]   result
);
    // Purpose: per-bit selection of data, sign copy or zero.
    always_comb begin
        for (int i = 0; i < XLEN; i++) begin
            if (i < BYTE_W)
                result[i] = data[i];
            else if (w32 && i >= HALF_W)
                result[i] = 1'b0;
            else
                result[i] = data[BYTE_W-1];
        end
    end
endmodule

// File: rtl/sbl_unit.sv
// Module: sbl_unit (top)
// Accepts a signed byte load word with its operand values, issues one
// byte read and returns the extended result plus optional base writeback.
// Assumes: one outstanding load; memory answers each accepted request once.
module sbl_unit
    import sbl_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter int SP_ALIGN_LG = 4,
    parameter int BYTE_W      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_valid,
    output logic               issue_ready,
    input  logic [31:0]        issue_instr,
    input  logic [XLEN-1:0]    issue_base,
    input  logic [XLEN-1:0]    issue_index,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [XLEN-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [BYTE_W-1:0]  mem_rsp_data,
    output logic               done_valid,
    output logic [4:0]         done_rt,
    output logic [XLEN-1:0]    done_result,
    output logic               done_wb_en,
    output logic [4:0]         done_wb_reg,
    output logic [XLEN-1:0]    done_wb_addr,
    output logic               done_undef,
    output logic               done_align_fault
);
    dec_t            dec;
    logic [XLEN-1:0] ag_addr;
    logic [XLEN-1:0] ag_wb;
    logic            ag_wb_en;
    logic            ag_fault;
    logic            issue_fire;
    logic            is_undef;

    state_e            state_q;
    logic [XLEN-1:0]   addr_q;
    logic [XLEN-1:0]   wb_q;
    logic              wb_en_q;
    logic [4:0]        rt_q;
    logic [4:0]        rn_q;
    logic              w32_q;
    logic              undef_q;
    logic              fault_q;
    logic [BYTE_W-1:0] data_q;

    sbl_decode u_decode (
        .instr (issue_instr),
        .dec   (dec)
    );

    sbl_agen #(
        .XLEN        (XLEN),
        .SP_ALIGN_LG (SP_ALIGN_LG)
    ) u_agen (
        .dec         (dec),
        .base        (issue_base),
        .index       (issue_index),
        .acc_addr    (ag_addr),
        .wb_addr     (ag_wb),
        .wb_en       (ag_wb_en),
        .align_fault (ag_fault)
    );

    sbl_sext #(
        .XLEN   (XLEN),
        .BYTE_W (BYTE_W)
    ) u_sext (
        .data   (data_q),
        .w32    (w32_q),
        .result (done_result)
    );

    // Purpose: handshake and status decode for the current offer.
    always_comb begin
        issue_ready = (state_q == ST_IDLE);
        issue_fire  = issue_valid && issue_ready;
        is_undef    = (dec.mode == AM_NONE);
    end

    // Purpose: sequence idle, request, wait and completion; capture operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wb_q    <= '0;
            wb_en_q <= 1'b0;
            rt_q    <= '0;
            rn_q    <= '0;
            w32_q   <= 1'b0;
            undef_q <= 1'b0;
            fault_q <= 1'b0;
            data_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (issue_fire) begin
                    addr_q  <= ag_addr;
                    wb_q    <= ag_wb;
                    rt_q    <= dec.rt;
                    rn_q    <= dec.rn;
                    w32_q   <= dec.w32;
                    undef_q <= is_undef;
                    fault_q <= ag_fault && !is_undef;
                    wb_en_q <= ag_wb_en && !ag_fault && !is_undef;
                    data_q  <= '0;
                    state_q <= (is_undef || ag_fault) ? ST_DONE : ST_REQ;
                end
                ST_REQ:  if (mem_req_ready) state_q <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    data_q  <= mem_rsp_data;
                    state_q <= ST_DONE;
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: drive the memory and completion ports from captured state.
    always_comb begin
        mem_req_valid    = (state_q == ST_REQ);
        mem_req_addr     = addr_q;
        done_valid       = (state_q == ST_DONE);
        done_rt          = rt_q;
        done_wb_en       = done_valid && wb_en_q;
        done_wb_reg      = rn_q;
        done_wb_addr     = wb_q;
        done_undef       = done_valid && undef_q;
        done_align_fault = done_valid && fault_q;
    end

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    assert_single_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready |=> !mem_req_valid);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    assert_busy_after_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fire |=> !issue_ready);

    assert_undef_noreq_R1: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fire && dec.mode == AM_NONE |=> !mem_req_valid && done_undef && !done_wb_en);

    assert_fault_noreq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fire && ag_fault |=> !mem_req_valid && (done_align_fault || done_undef));

    assert_narrow_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && w32_q |-> done_result[XLEN-1:XLEN/2] == '0);
endmodule

// File: tb/sbl_unit_tb_top.sv
`timescale 1ns/1ps
module sbl_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic        issue_ready;
    logic [31:0] issue_instr = '0;
    logic [63:0] issue_base = '0;
    logic [63:0] issue_index = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [7:0]  mem_rsp_data = '0;
    logic        done_valid;
    logic [4:0]  done_rt;
    logic [63:0] done_result;
    logic        done_wb_en;
    logic [4:0]  done_wb_reg;
    logic [63:0] done_wb_addr;
    logic        done_undef;
    logic        done_align_fault;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sbl_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_ready(issue_ready),
        .issue_instr(issue_instr), .issue_base(issue_base), .issue_index(issue_index),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done_valid(done_valid), .done_rt(done_rt),
        .done_result(done_result), .done_wb_en(done_wb_en), .done_wb_reg(done_wb_reg),
        .done_wb_addr(done_wb_addr), .done_undef(done_undef),
        .done_align_fault(done_align_fault)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_uimm(bit w, int imm12, int rn, int rt);
        return (w ? 32'h39C0_0000 : 32'h3980_0000) | (32'(imm12) << 10) |
               (32'(rn) << 5) | 32'(rt);
    endfunction

    function automatic logic [31:0] enc_idx(bit w, bit pre, int imm9, int rn, int rt);
        return (w ? 32'h38C0_0400 : 32'h3880_0400) | (pre ? 32'h800 : 32'h0) |
               ((32'(imm9) & 32'h1FF) << 12) | (32'(rn) << 5) | 32'(rt);
    endfunction

    function automatic logic [31:0] enc_reg(bit w, int rm, int opt, bit s, int rn, int rt);
        return (w ? 32'h38E0_0800 : 32'h38A0_0800) | (32'(rm) << 16) |
               (32'(opt) << 13) | (32'(s) << 12) | (32'(rn) << 5) | 32'(rt);
    endfunction

    // One load from offer to completion; stall delays mem_req_ready.
    task automatic run_load(string req, logic [31:0] ins, logic [63:0] base,
                            logic [63:0] idx, logic [7:0] byte_v, bit exp_undef,
                            bit exp_fault, logic [63:0] exp_addr, logic [63:0] exp_res,
                            bit exp_wb, logic [63:0] exp_wb_addr, int stall);
        bit seen = 1'b0;
        bit got = 1'b0;
        int hold = stall;
        @(negedge clk);
        issue_valid = 1'b1; issue_instr = ins; issue_base = base; issue_index = idx;
        @(negedge clk);
        issue_valid = 1'b0;
        for (int c = 0; c < 40; c++) begin
            if (done_valid) begin
                mem_rsp_valid = 1'b0;
                got = 1'b1;
                chk(req, "undef", 64'(done_undef), 64'(exp_undef));
                chk(req, "align_fault", 64'(done_align_fault), 64'(exp_fault));
                chk(req, "wb_en", 64'(done_wb_en), 64'(exp_wb));
                chk(req, "request made", 64'(seen), 64'(!exp_undef && !exp_fault));
                if (!exp_undef && !exp_fault) begin
                    chk(req, "result", done_result, exp_res);
                    chk(req, "rt", 64'(done_rt), 64'(ins[4:0]));
                end
                if (exp_wb) begin
                    chk(req, "wb_addr", done_wb_addr, exp_wb_addr);
                    chk(req, "wb_reg", 64'(done_wb_reg), 64'(ins[9:5]));
                end
                break;
            end
            if (mem_req_valid && !mem_req_ready) begin
                if (!seen) chk(req, "mem_req_addr", mem_req_addr, exp_addr);
                else chk("R8", "held mem_req_addr", mem_req_addr, exp_addr);
                seen = 1'b1;
                chk("R9", "issue_ready while busy", 64'(issue_ready), 64'd0);
                if (hold > 0) begin
                    hold--;
                    issue_valid = 1'b1;
                    issue_instr = enc_uimm(1'b1, 7, 2, 9);
                end else begin
                    issue_valid = 1'b0;
                    mem_req_ready = 1'b1;
                end
            end else if (mem_req_ready) begin
                mem_req_ready = 1'b0;
                mem_rsp_valid = 1'b1;
                mem_rsp_data = byte_v;
            end else begin
                mem_rsp_valid = 1'b0;
            end
            @(negedge clk);
        end
        chk(req, "completion seen", 64'(got), 64'd1);
        @(negedge clk);
        chk("R9", "done_valid one cycle", 64'(done_valid), 64'd0);
    endtask

    task automatic t_reset();
        chk("R10", "issue_ready", 64'(issue_ready), 64'd1);
        chk("R10", "mem_req_valid", 64'(mem_req_valid), 64'd0);
        chk("R10", "done_valid", 64'(done_valid), 64'd0);
    endtask

    task automatic t_uimm();
        run_load("R2", enc_uimm(1'b1, 16, 1, 3), 64'h1000, '0, 8'h80, 0, 0,
                 64'h1010, 64'h0000_0000_FFFF_FF80, 0, '0, 0);
        run_load("R2", enc_uimm(1'b0, 4095, 4, 5), 64'h2_0000, '0, 8'h7F, 0, 0,
                 64'h2_0FFF, 64'h7F, 0, '0, 0);
        run_load("R6", enc_uimm(1'b0, 0, 6, 7), 64'h40, '0, 8'hF0, 0, 0,
                 64'h40, 64'hFFFF_FFFF_FFFF_FFF0, 0, '0, 0);
    endtask

    task automatic t_post();
        run_load("R4", enc_idx(1'b1, 1'b0, -1, 2, 8), 64'h2000, '0, 8'h01, 0, 0,
                 64'h2000, 64'h1, 1, 64'h1FFF, 0);
    endtask

    task automatic t_pre();
        run_load("R3", enc_idx(1'b0, 1'b1, 255, 3, 9), 64'h3000, '0, 8'h81, 0, 0,
                 64'h30FF, 64'hFFFF_FFFF_FFFF_FF81, 1, 64'h30FF, 0);
        run_load("R3", enc_idx(1'b1, 1'b1, -256, 10, 11), 64'h4000, '0, 8'h55, 0, 0,
                 64'h3F00, 64'h55, 1, 64'h3F00, 0);
    endtask

    task automatic t_regoff();
        run_load("R5", enc_reg(1'b1, 2, 3'b010, 1'b0, 1, 4), 64'h10,
                 64'hFFFF_FFFF_8000_0000, 8'h02, 0, 0, 64'h8000_0010, 64'h2, 0, '0, 0);
        run_load("R5", enc_reg(1'b0, 2, 3'b110, 1'b0, 1, 4), 64'h100,
                 64'h0000_0000_FFFF_FFF0, 8'hFE, 0, 0, 64'hF0,
                 64'hFFFF_FFFF_FFFF_FFFE, 0, '0, 0);
        run_load("R5", enc_reg(1'b1, 2, 3'b011, 1'b1, 1, 4), 64'h8,
                 64'h1_0000_0000, 8'h10, 0, 0, 64'h1_0000_0008, 64'h10, 0, '0, 0);
        run_load("R5", enc_reg(1'b0, 2, 3'b111, 1'b1, 1, 4), 64'h8,
                 64'hFFFF_FFFF_FFFF_FFF8, 8'h20, 0, 0, 64'h0, 64'h20, 0, '0, 0);
    endtask

    task automatic t_sp();
        run_load("R7", enc_uimm(1'b1, 8, 31, 1), 64'h8000, '0, 8'h33, 0, 0,
                 64'h8008, 64'h33, 0, '0, 0);
        run_load("R7", enc_idx(1'b0, 1'b1, 16, 31, 1), 64'h8008, '0, 8'h33, 0, 1,
                 '0, '0, 0, '0, 0);
    endtask

    task automatic t_undef();
        run_load("R1", 32'h38C0_0000, 64'h100, '0, 8'h00, 1, 0, '0, '0, 0, '0, 0);
        run_load("R1", 32'h3940_0000, 64'h100, '0, 8'h00, 1, 0, '0, '0, 0, '0, 0);
        run_load("R1", enc_reg(1'b1, 2, 3'b000, 1'b0, 1, 4), 64'h100, 64'h4,
                 8'h00, 1, 0, '0, '0, 0, '0, 0);
    endtask

    task automatic t_stall();
        run_load("R8", enc_uimm(1'b1, 1, 12, 13), 64'h500, '0, 8'hC3, 0, 0,
                 64'h501, 64'h0000_0000_FFFF_FFC3, 0, '0, 3);
    endtask

    initial begin
        #(200000 * 5.0);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_uimm();
        t_post();
        t_pre();
        t_regoff();
        t_sp();
        t_undef();
        t_stall();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule